// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 16-bit memory address for one operand of a small accumulator-style processor. Each request carries an addressing-mode code, an operand field taken from the instruction stream, a base register choice, an accumulator choice and a snapshot of the index registers, stack pointer, program counter and accumulators. The unit answers with the address. For auto-adjust forms it also returns the value to write back into the chosen base register, together with a write enable. A mode and register pairing that is not allowed raises a flag instead.

Requests arrive over a valid/ready handshake. One result sits in a registered output slot until the consumer takes it. A new request is accepted in the same cycle that the previous result is taken, so back-to-back traffic runs at one address per cycle. The unit holds no registers of the processor itself. The decoder upstream supplies the register values, and the writeback goes back to the register file.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (page-zero) gives an address of operand bits [7:0] with the upper byte forced to zero.
- R2: Mode code 1 (absolute) uses the whole 16-bit operand unchanged as the address.
- R3: Mode code 2 adds operand bits [7:0], sign-extended, to PC. Mode code 3 adds the full 16-bit operand to PC. The base select input has no effect on either mode.
- R4: Mode code 4 adds operand bits [4:0], sign-extended (−16..+15), to the base. Base select 0 = X, 1 = Y, 2 = SP, 3 = PC.
- R5: Mode code 5 adds operand bits [8:0], sign-extended (−256..+255), to the base chosen as in R4.
- R6: Mode code 6 adds an accumulator to the base. Accumulator select 0 = A and 1 = B, each zero-extended to 16 bits, and 2 = D.
- R7: Mode codes 7 (pre-increment) and 8 (pre-decrement) adjust the base by (operand[2:0] + 1). The adjusted value is both the address and the writeback value, and writeback enable is 1.
- R8: Mode codes 9 (post-increment) and 10 (post-decrement) output the unadjusted base as the address. They output the base adjusted by (operand[2:0] + 1) as the writeback value, with writeback enable 1.
- R9: All address and writeback arithmetic wraps modulo 2^16.
- R10: The illegal flag is 1 for any of: mode codes 11..15, mode codes 7..10 with base select 3, or mode 6 with accumulator select 3. When the flag is 1, the address and writeback value are 0 and writeback enable is 0. Every mode other than 7..10 also gives writeback enable 0 and writeback value 0.
- R11: in_ready equals (not out_valid) or out_ready. An accepted request appears on the outputs with out_valid high one clock later. While out_valid is high and out_ready is low, all result outputs stay unchanged.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| mode_i | input | 4 | Addressing-mode code |
| opnd_i | input | 16 | Operand field from the instruction stream |
| base_sel_i | input | 2 | Base register choice |
| acc_sel_i | input | 2 | Accumulator choice for mode 6 |
| x_i | input | 16 | Index register X |
| y_i | input | 16 | Index register Y |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | Program counter |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| d_i | input | 16 | Double accumulator D |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| ea_o | output | 16 | Effective address |
| wb_val_o | output | 16 | Base register writeback value |
| wb_en_o | output | 1 | Writeback enable |
| bad_o | output | 1 | Illegal mode/register pairing |

## Verification
Every cycle, the assertions check the following:
- a page-zero result never reaches above the first 256 bytes;
- pre-adjust forms give the same value for the address and the writeback, and that value always differs from the base;
- post-adjust forms return the base itself as the address;
- a flagged result is fully quiet;
- a stalled result does not move;
- an empty output slot always accepts.

Only the bench's reference model and scenarios can show the actual address arithmetic. That covers sign extension at each offset width, zero extension of the byte accumulators, wrap-around at the 16-bit boundary, the separate legality cases, and the order of back-to-back results.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [3:0] {
      M_DIR     = 4'd0,
      M_EXT     = 4'd1,
      M_REL8    = 4'd2,
      M_REL16   = 4'd3,
      M_IDX5    = 4'd4,
      M_IDX9    = 4'd5,
      M_IDXACC  = 4'd6,
      M_PREINC  = 4'd7,
      M_PREDEC  = 4'd8,
      M_POSTINC = 4'd9,
      M_POSTDEC = 4'd10
   } ea_mode_e;

   localparam logic [1:0] BSEL_X  = 2'd0;
   localparam logic [1:0] BSEL_Y  = 2'd1;
   localparam logic [1:0] BSEL_SP = 2'd2;
   localparam logic [1:0] BSEL_PC = 2'd3;

   localparam logic [1:0] ASEL_A = 2'd0;
   localparam logic [1:0] ASEL_B = 2'd1;
   localparam logic [1:0] ASEL_D = 2'd2;

   function automatic logic is_auto(input ea_mode_e m);
      return (m == M_PREINC) || (m == M_PREDEC) ||
             (m == M_POSTINC) || (m == M_POSTDEC);
   endfunction

   function automatic logic is_pre(input ea_mode_e m);
      return (m == M_PREINC) || (m == M_PREDEC);
   endfunction

   function automatic logic is_dec(input ea_mode_e m);
      return (m == M_PREDEC) || (m == M_POSTDEC);
   endfunction

   function automatic logic is_rel(input ea_mode_e m);
      return (m == M_REL8) || (m == M_REL16);
   endfunction

   function automatic logic is_known(input logic [3:0] code);
      return code <= 4'(M_POSTDEC);
   endfunction

endpackage

// File: rtl/ea_base_sel.sv
module ea_base_sel #(
   parameter int AW   = 16,
   parameter int NREG = 4,
   localparam int SW  = $clog2(NREG)
) (
   input  logic [NREG-1:0][AW-1:0] bank,
   input  logic [SW-1:0]           sel,
   output logic [AW-1:0]           base
);

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("ea_base_sel: NREG must be at least 2");
      end
   endgenerate

   // AND-OR one-hot selection: balanced depth regardless of NREG
   logic [NREG-1:0][AW-1:0] gated;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_slot
         assign gated[g] = (sel == SW'(g)) ? bank[g] : '0;
      end
   endgenerate

   always_comb begin
      base = '0;
      for (int k = 0; k < NREG; k++) begin
         base = base | gated[k];
      end
   end

endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
   import ea_pkg::*;
#(
   parameter int AW      = 16,
   parameter int PAGE_W  = 8,
   parameter int SOFS_W  = 5,
   parameter int WOFS_W  = 9,
   parameter int ACC_W   = 8
) (
   input  ea_mode_e          mode,
   input  logic [AW-1:0]     opnd,
   input  logic [1:0]        acc_sel,
   input  logic [ACC_W-1:0]  acc_a,
   input  logic [ACC_W-1:0]  acc_b,
   input  logic [AW-1:0]     acc_d,
   output logic [AW-1:0]     ofs,
   output logic              acc_bad
);

   localparam int PAGE_PAD = AW - PAGE_W;
   localparam int SOFS_PAD = AW - SOFS_W;
   localparam int WOFS_PAD = AW - WOFS_W;
   localparam int ACC_PAD  = AW - ACC_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= AW) begin : g_chk_page
         $error("ea_offset_gen: PAGE_W must lie in 1..AW-1");
      end
      if (SOFS_W < 2 || SOFS_W >= WOFS_W) begin : g_chk_sofs
         $error("ea_offset_gen: SOFS_W must be >=2 and below WOFS_W");
      end
      if (WOFS_W >= AW) begin : g_chk_wofs
         $error("ea_offset_gen: WOFS_W must be below AW");
      end
      if (ACC_W < 1 || ACC_W >= AW) begin : g_chk_acc
         $error("ea_offset_gen: ACC_W must lie in 1..AW-1");
      end
   endgenerate

   logic [AW-1:0] page_z, page_s, short_s, wide_s, acc_val;

   assign page_z  = {{PAGE_PAD{1'b0}}, opnd[PAGE_W-1:0]};
   assign page_s  = {{PAGE_PAD{opnd[PAGE_W-1]}}, opnd[PAGE_W-1:0]};
   assign short_s = {{SOFS_PAD{opnd[SOFS_W-1]}}, opnd[SOFS_W-1:0]};
   assign wide_s  = {{WOFS_PAD{opnd[WOFS_W-1]}}, opnd[WOFS_W-1:0]};

   always_comb begin
      acc_val = '0;
      acc_bad = 1'b0;
      case (acc_sel)
         ASEL_A:  acc_val = {{ACC_PAD{1'b0}}, acc_a};
         ASEL_B:  acc_val = {{ACC_PAD{1'b0}}, acc_b};
         ASEL_D:  acc_val = acc_d;
         default: acc_bad = 1'b1;
      endcase
      if (mode != M_IDXACC) acc_bad = 1'b0;
   end

   always_comb begin
      case (mode)
         M_DIR:            ofs = page_z;
         M_EXT, M_REL16:   ofs = opnd;
         M_REL8:           ofs = page_s;
         M_IDX5:           ofs = short_s;
         M_IDX9:           ofs = wide_s;
         M_IDXACC:         ofs = acc_val;
         default:          ofs = '0;
      endcase
   end

endmodule

// File: rtl/ea_step_unit.sv
module ea_step_unit #(
   parameter int AW       = 16,
   parameter int STEP_W   = 3,
   parameter bit STEP_SUB = 1'b1
) (
   input  logic [AW-1:0]     base,
   input  logic [STEP_W-1:0] field,
   input  logic              dec,
   output logic [AW-1:0]     adj
);

   generate
      if (STEP_W < 1 || STEP_W >= AW) begin : g_chk_step
         $error("ea_step_unit: STEP_W must lie in 1..AW-1");
      end
   endgenerate

   logic [AW-1:0] amt;
   assign amt = {{(AW-STEP_W){1'b0}}, field} + {{(AW-1){1'b0}}, 1'b1};

   generate
      if (STEP_SUB) begin : g_addsub
         // separate add and subtract paths, selected at the end
         logic [AW-1:0] up, down;
         assign up   = base + amt;
         assign down = base - amt;
         assign adj  = dec ? down : up;
      end else begin : g_negadd
         // one adder fed with the two's complement of the step when decrementing
         logic [AW-1:0] opb;
         assign opb = dec ? (~amt + {{(AW-1){1'b0}}, 1'b1}) : amt;
         assign adj = base + opb;
      end
   endgenerate

endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int AW       = 16,
   parameter int PAGE_W   = 8,
   parameter int SOFS_W   = 5,
   parameter int WOFS_W   = 9,
   parameter int STEP_W   = 3,
   parameter int ACC_W    = 8,
   parameter bit STEP_SUB = 1'b1,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [3:0]        mode_i,
   input  logic [AW-1:0]     opnd_i,
   input  logic [1:0]        base_sel_i,
   input  logic [1:0]        acc_sel_i,
   input  logic [AW-1:0]     x_i,
   input  logic [AW-1:0]     y_i,
   input  logic [AW-1:0]     sp_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [ACC_W-1:0]  a_i,
   input  logic [ACC_W-1:0]  b_i,
   input  logic [AW-1:0]     d_i,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     ea_o,
   output logic [AW-1:0]     wb_val_o,
   output logic              wb_en_o,
   output logic              bad_o
);

   localparam int NREG = 4;

   generate
      if (AW < 2 * PAGE_W) begin : g_chk_aw
         $error("ea_unit: AW must hold at least two pages of address bits");
      end
   endgenerate

   ea_mode_e mode;
   assign mode = ea_mode_e'(mode_i);

   // ---------------- base selection ----------------
   logic [NREG-1:0][AW-1:0] bank;
   logic [1:0]              sel_eff;
   logic [AW-1:0]           base;

   assign bank    = {pc_i, sp_i, y_i, x_i};
   assign sel_eff = is_rel(mode) ? BSEL_PC : base_sel_i;

   ea_base_sel #(.AW(AW), .NREG(NREG)) u_base (
      .bank (bank),
      .sel  (sel_eff),
      .base (base)
   );

   // ---------------- offset formation ----------------
   logic [AW-1:0] ofs;
   logic          acc_bad;

   ea_offset_gen #(
      .AW(AW), .PAGE_W(PAGE_W), .SOFS_W(SOFS_W), .WOFS_W(WOFS_W), .ACC_W(ACC_W)
   ) u_ofs (
      .mode    (mode),
      .opnd    (opnd_i),
      .acc_sel (acc_sel_i),
      .acc_a   (a_i),
      .acc_b   (b_i),
      .acc_d   (d_i),
      .ofs     (ofs),
      .acc_bad (acc_bad)
   );

   // ---------------- auto adjust ----------------
   logic [AW-1:0] adj;

   ea_step_unit #(.AW(AW), .STEP_W(STEP_W), .STEP_SUB(STEP_SUB)) u_step (
      .base  (base),
      .field (opnd_i[STEP_W-1:0]),
      .dec   (is_dec(mode)),
      .adj   (adj)
   );

   // ---------------- combine ----------------
   logic [AW-1:0] sum;
   logic          legal;
   logic [AW-1:0] ea_d, wb_d;
   logic          wbe_d;

   assign sum   = base + ofs;
   assign legal = is_known(mode_i) && !acc_bad &&
                  !(is_auto(mode) && (base_sel_i == BSEL_PC));

   always_comb begin
      ea_d  = '0;
      wb_d  = '0;
      wbe_d = 1'b0;
      if (legal) begin
         case (mode)
            M_DIR, M_EXT: ea_d = ofs;
            M_PREINC, M_PREDEC: begin
               ea_d  = adj;
               wb_d  = adj;
               wbe_d = 1'b1;
            end
            M_POSTINC, M_POSTDEC: begin
               ea_d  = base;
               wb_d  = adj;
               wbe_d = 1'b1;
            end
            default: ea_d = sum;
         endcase
      end
   end

   // ---------------- output stage ----------------
   generate
      if (OUT_REG) begin : g_reg
         logic          v_q;
         logic [AW-1:0] ea_q, wb_q;
         logic          wbe_q, bad_q;
         logic          fire;

         assign in_ready = !v_q || out_ready;
         assign fire     = in_valid && in_ready;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q   <= 1'b0;
               ea_q  <= '0;
               wb_q  <= '0;
               wbe_q <= 1'b0;
               bad_q <= 1'b0;
            end else if (fire) begin
               v_q   <= 1'b1;
               ea_q  <= ea_d;
               wb_q  <= wb_d;
               wbe_q <= wbe_d;
               bad_q <= !legal;
            end else if (out_ready) begin
               v_q   <= 1'b0;
            end
         end

         assign out_valid = v_q;
         assign ea_o      = ea_q;
         assign wb_val_o  = wb_q;
         assign wb_en_o   = wbe_q;
         assign bad_o     = bad_q;

         AST_DIR_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && mode_i == 4'(M_DIR)) |-> (ea_d[AW-1:PAGE_W] == '0))
            else $error("page-zero address above first page"); // R1

         AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && legal && is_pre(mode)) |-> (ea_d == wb_d && wb_d != base))
            else $error("pre-adjust address and writeback disagree"); // R7

         AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && legal && is_auto(mode) && !is_pre(mode)) |-> (ea_d == base && wb_d != base))
            else $error("post-adjust address is not the base"); // R8

         AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q && bad_q) |-> (ea_q == '0 && wb_q == '0 && !wbe_q))
            else $error("flagged result is not quiet"); // R10

         AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q && !out_ready) |=> (v_q && $stable(ea_q) && $stable(wb_q) &&
                                     $stable(wbe_q) && $stable(bad_q)))
            else $error("stalled result changed"); // R11

         AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
            !v_q |-> in_ready)
            else $error("empty slot refused a request"); // R12
      end else begin : g_pass
         assign in_ready  = out_ready;
         assign out_valid = in_valid;
         assign ea_o      = ea_d;
         assign wb_val_o  = wb_d;
         assign wb_en_o   = wbe_d;
         assign bad_o     = !legal;
      end
   endgenerate

endmodule

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  mode_i = '0;
   logic [15:0] opnd_i = '0;
   logic [1:0]  base_sel_i = '0;
   logic [1:0]  acc_sel_i = '0;
   logic [15:0] x_i = '0, y_i = '0, sp_i = '0, pc_i = '0, d_i = '0;
   logic [7:0]  a_i = '0, b_i = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [15:0] ea_o, wb_val_o;
   logic        wb_en_o, bad_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .mode_i(mode_i), .opnd_i(opnd_i), .base_sel_i(base_sel_i), .acc_sel_i(acc_sel_i),
      .x_i(x_i), .y_i(y_i), .sp_i(sp_i), .pc_i(pc_i), .a_i(a_i), .b_i(b_i), .d_i(d_i),
      .out_valid(out_valid), .out_ready(out_ready),
      .ea_o(ea_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o), .bad_o(bad_o)
   );

   // reference model: {bad, wb_en, wb_val, ea}
   function automatic logic [33:0] model(input logic [3:0] m, input logic [15:0] op,
         input logic [1:0] bs, input logic [1:0] as, input logic [15:0] x, input logic [15:0] y,
         input logic [15:0] sp, input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b,
         input logic [15:0] d);
      logic [15:0] base, e, w, amt;
      logic bad, we;
      base = (bs == 2'd0) ? x : (bs == 2'd1) ? y : (bs == 2'd2) ? sp : pc;
      amt  = {13'd0, op[2:0]} + 16'd1;
      e = '0; w = '0; we = 1'b0; bad = 1'b0;
      case (m)
         4'd0:  e = {8'h00, op[7:0]};
         4'd1:  e = op;
         4'd2:  e = pc + {{8{op[7]}}, op[7:0]};
         4'd3:  e = pc + op;
         4'd4:  e = base + {{11{op[4]}}, op[4:0]};
         4'd5:  e = base + {{7{op[8]}}, op[8:0]};
         4'd6:  case (as)
                   2'd0: e = base + {8'h00, a};
                   2'd1: e = base + {8'h00, b};
                   2'd2: e = base + d;
                   default: bad = 1'b1;
                endcase
         4'd7, 4'd8, 4'd9, 4'd10: begin
            if (bs == 2'd3) bad = 1'b1;
            else begin
               w  = (m == 4'd7 || m == 4'd9) ? base + amt : base - amt;
               e  = (m <= 4'd8) ? w : base;
               we = 1'b1;
            end
         end
         default: bad = 1'b1;
      endcase
      if (bad) begin e = '0; w = '0; we = 1'b0; end
      return {bad, we, w, e};
   endfunction

   function automatic string tag_of(input logic [3:0] m, input logic [1:0] bs, input logic [1:0] as);
      if (m == 4'd0) return "R1";
      if (m == 4'd1) return "R2";
      if (m == 4'd2 || m == 4'd3) return "R3";
      if (m == 4'd4) return "R4";
      if (m == 4'd5) return "R5";
      if (m == 4'd6) return (as == 2'd3) ? "R10" : "R6";
      if (m == 4'd7 || m == 4'd8) return (bs == 2'd3) ? "R10" : "R7";
      if (m == 4'd9 || m == 4'd10) return (bs == 2'd3) ? "R10" : "R8";
      return "R10";
   endfunction

   task automatic check_bit(input logic act, input logic exp, input string tag, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic check_out(input logic [33:0] exp, input string tag);
      n_chk++;
      if (out_valid !== 1'b1 || {bad_o, wb_en_o, wb_val_o, ea_o} !== exp) begin
         n_bad++;
         $display("FAIL %s: actual v=%0b bad=%0b we=%0b wb=%h ea=%h expected v=1 bad=%0b we=%0b wb=%h ea=%h",
                  tag, out_valid, bad_o, wb_en_o, wb_val_o, ea_o,
                  exp[33], exp[32], exp[31:16], exp[15:0]);
      end
   endtask

   task automatic drive(input logic [3:0] m, input logic [15:0] op, input logic [1:0] bs,
         input logic [1:0] as, input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp,
         input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b, input logic [15:0] d);
      mode_i = m; opnd_i = op; base_sel_i = bs; acc_sel_i = as;
      x_i = x; y_i = y; sp_i = sp; pc_i = pc; a_i = a; b_i = b; d_i = d;
   endtask

   // one request, optional stall, then release; starts and ends at a negedge with empty slot
   task automatic run(input logic [3:0] m, input logic [15:0] op, input logic [1:0] bs,
         input logic [1:0] as, input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp,
         input logic [15:0] pc, input logic [7:0] a, input logic [7:0] b, input logic [15:0] d,
         input int stall, input string tag);
      logic [33:0] exp;
      string t;
      exp = model(m, op, bs, as, x, y, sp, pc, a, b, d);
      t   = (tag == "") ? tag_of(m, bs, as) : tag;
      drive(m, op, bs, as, x, y, sp, pc, a, b, d);
      in_valid  = 1'b1;
      out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      drive(4'd0, $urandom(), 2'd0, 2'd0, $urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom());
      check_out(exp, t);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         check_out(exp, "R11 stall");
         check_bit(in_ready, 1'b0, "R11", "in_ready during stall");
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check_bit(out_valid, 1'b0, "R11", "slot empty after take");
   endtask

   task automatic finish_up();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_up();
      end
   end

   initial begin
      logic [33:0] e1, e2;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      check_bit(out_valid, 1'b0, "R12", "out_valid after reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_bit(out_valid, 1'b0, "R12", "out_valid idle");
      check_bit(in_ready, 1'b1, "R12", "in_ready idle");

      // directed corners
      run(4'd0, 16'hABCD, 2'd1, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R1");
      run(4'd1, 16'hFEDC, 2'd0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R2");
      run(4'd2, 16'h0080, 2'd0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R3");
      run(4'd3, 16'h8000, 2'd2, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R3");
      run(4'd4, 16'h0010, 2'd1, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R4");
      run(4'd4, 16'h000F, 2'd3, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R4");
      run(4'd5, 16'h0100, 2'd2, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R5");
      run(4'd5, 16'h00FF, 2'd0, 2'd0, 16'hFFF0, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R9");
      run(4'd6, 16'h0000, 2'd0, 2'd0, 16'h1000, 16'h2222, 16'h3333, 16'h4444, 8'hF0, 8'h00, 16'h0, 0, "R6");
      run(4'd6, 16'h0000, 2'd1, 2'd1, 16'h1000, 16'h2000, 16'h3333, 16'h4444, 8'h00, 8'h80, 16'h0, 0, "R6");
      run(4'd6, 16'h0000, 2'd3, 2'd2, 16'h1000, 16'h2000, 16'h3333, 16'hF000, 8'h00, 8'h80, 16'h2345, 0, "R9");
      run(4'd6, 16'h0000, 2'd0, 2'd3, 16'h1000, 16'h2000, 16'h3333, 16'h4444, 8'h11, 8'h22, 16'h3344, 0, "R10");
      run(4'd7, 16'h0007, 2'd2, 2'd0, 16'h1111, 16'h2222, 16'hFFFC, 16'h4444, 8'h00, 8'h00, 16'h0, 2, "R7");
      run(4'd8, 16'h0000, 2'd0, 2'd0, 16'h0000, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R7");
      run(4'd9, 16'h0003, 2'd1, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R8");
      run(4'd10, 16'h0007, 2'd2, 2'd0, 16'h1111, 16'h2222, 16'h0004, 16'h4444, 8'h00, 8'h00, 16'h0, 3, "R8");
      run(4'd7, 16'h0002, 2'd3, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R10");
      run(4'd10, 16'h0002, 2'd3, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R10");
      run(4'd11, 16'h1234, 2'd0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 0, "R10");
      run(4'd15, 16'hFFFF, 2'd1, 2'd1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h00, 8'h00, 16'h0, 1, "R10");

      // back-to-back: second request accepted in the cycle the first is taken (R11)
      e1 = model(4'd4, 16'h0003, 2'd0, 2'd0, 16'h0100, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
      e2 = model(4'd9, 16'h0001, 2'd1, 2'd0, 16'h0, 16'h0200, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
      drive(4'd4, 16'h0003, 2'd0, 2'd0, 16'h0100, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      check_out(e1, "R11 b2b first");
      check_bit(in_ready, 1'b1, "R11", "in_ready with out_ready high");
      drive(4'd9, 16'h0001, 2'd1, 2'd0, 16'h0, 16'h0200, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0);
      @(negedge clk);
      check_out(e2, "R11 b2b second");
      in_valid = 1'b0;
      @(negedge clk);
      out_ready = 1'b0;
      check_bit(out_valid, 1'b0, "R11", "drained after b2b");

      // constrained random
      for (int it = 0; it < 800; it++) begin
         logic [3:0] m;
         m = (($urandom() % 8) == 0) ? 4'($urandom()) : 4'($urandom() % 11);
         run(m, 16'($urandom()), 2'($urandom()), 2'($urandom()),
             16'($urandom()), 16'($urandom()), 16'($urandom()), 16'($urandom()),
             8'($urandom()), 8'($urandom()), 16'($urandom()), int'($urandom() % 3), "");
      end

      done = 1'b1;
      finish_up();
   end

endmodule